// File: doc/BRIEF.md
# Swapping Victim Buffer

A small fully-associative store of recently evicted blocks that sits beside a direct-mapped main cache. Each block that the main cache evicts is placed here. When the main cache misses, the controller presents the missing block address to this buffer. If that address is held here, the block goes back to the main cache and no next-level access is needed. The block that the main cache evicts in exchange takes over the slot that the returned block occupied.

One request runs per cycle and requests do not overlap. The request carries the lookup address and, when the main cache has one, the evicted block with its address, data and dirty flag. Hit status, hit data and any displaced writeback appear combinationally in the request cycle. Storage and recency are updated at the following clock edge. Recency is held as a rank per slot, with rank 0 the most recent. A fill on a miss overwrites the slot with the highest rank. A swap on a hit makes its slot the most recent and leaves every other slot's contents unchanged. A hit that brings no evicted block with it frees its slot and moves that slot to the oldest rank.

Top module: `vc_swap_buf`

## Requirements
- R1: After reset every slot is empty: no lookup address, including zero, gives hit_o, and the first fills drive no eviction.
- R2: While req_i is high and lk_addr_i equals the address of a held entry, hit_o is 1 in the same cycle, and hit_data_o and hit_dirty_o show that entry's data and dirty flag.
- R3: A request that misses with ins_valid_i high stores the incoming block in the least recently used slot, and that block becomes the most recently used.
- R4: A request that hits with ins_valid_i high writes the incoming block into the slot of the hit entry and makes it the most recent. The hit entry is then no longer held, and no other entry is displaced or changed.
- R5: A request that hits with ins_valid_i low empties the hit slot and makes it the least recent, so the next fill uses that slot.
- R6: When a fill displaces a valid dirty entry, evict_valid_o is 1 in the same cycle and evict_addr_o and evict_data_o show the displaced entry. A displaced clean entry, or a fill into an empty slot, leaves evict_valid_o at 0.
- R7: A request that misses with ins_valid_i low changes no stored state.
- R8: While req_i is low, hit_o and evict_valid_o are 0 and no state changes.
- R9: A hit refreshes recency, so that entries are displaced in order of last use.
- R10: When two blocks that conflict in the main cache alternate, the buffer misses once and afterwards hits on every access, swapping the pair without displacing other entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid (a main-cache miss) |
| lk_addr_i | input | ADDR_W | Block address being looked up |
| ins_valid_i | input | 1 | An evicted block comes with this request |
| ins_addr_i | input | ADDR_W | Evicted block address |
| ins_data_i | input | DATA_W | Evicted block data |
| ins_dirty_i | input | 1 | Evicted block is dirty |
| hit_o | output | 1 | Lookup hit |
| hit_data_o | output | DATA_W | Data of the hit entry |
| hit_dirty_o | output | 1 | Dirty flag of the hit entry |
| evict_valid_o | output | 1 | A dirty entry is displaced toward the next level |
| evict_addr_o | output | ADDR_W | Displaced entry address |
| evict_data_o | output | DATA_W | Displaced entry data |

## Verification
Assertions check these rules on every cycle: at most one slot matches a lookup, hit and eviction stay low when there is no request, eviction happens only on a fill that misses, a block stored in one cycle is found with its data in the next, and an entry taken by a hit can no longer be found. Whether a fill picks the least recently used slot, whether a swap leaves the oldest entry in place, and whether a freed slot is the next to be reused all depend on a history of several requests. Only the bench's scenarios show these, through the order of later evictions and misses.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_NOP  = 2'd0,
    VC_FILL = 2'd1,
    VC_SWAP = 2'd2,
    VC_TAKE = 2'd3
  } vc_op_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0]        key_i,
  output logic [N-1:0]             match_o,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (addr_i[g] == key_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (match_o[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N      = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             demote_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rank_q [N];
  logic [IDX_W-1:0] ref_rank;

  assign ref_rank = rank_q[idx_i];

  // ranks stay a permutation; empty slots always hold the oldest ranks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (upd_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == idx_i)
          rank_q[i] <= demote_i ? OLDEST : '0;
        else if (demote_i && rank_q[i] > ref_rank)
          rank_q[i] <= rank_q[i] - 1'b1;
        else if (!demote_i && rank_q[i] < ref_rank)
          rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (rank_q[i] == OLDEST) lru_idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         widx_i,
  input  logic                     wvalid_i,
  input  logic                     wdirty_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [N-1:0]             valid_o,
  output logic [N-1:0]             dirty_o,
  output logic [N-1:0][ADDR_W-1:0] addr_o,
  output logic [N-1:0][DATA_W-1:0] data_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel;
    assign sel = we_i && (widx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        dirty_o[g] <= 1'b0;
        addr_o[g]  <= '0;
        data_o[g]  <= '0;
      end else if (sel) begin
        valid_o[g] <= wvalid_i;
        dirty_o[g] <= wvalid_i && wdirty_i;
        addr_o[g]  <= waddr_i;
        data_o[g]  <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/vc_swap_buf.sv
module vc_swap_buf
  import vc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [DATA_W-1:0] ins_data_i,
  input  logic              ins_dirty_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  output logic              hit_dirty_o,
  output logic              evict_valid_o,
  output logic [ADDR_W-1:0] evict_addr_o,
  output logic [DATA_W-1:0] evict_data_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             slot_valid, slot_dirty, match_vec;
  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr;
  logic [ENTRIES-1:0][DATA_W-1:0] slot_data;
  logic                           any_match;
  logic [IDX_W-1:0]               hit_idx, lru_idx, tgt_idx;
  vc_op_e                         op;

  vc_match #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .valid_i (slot_valid),
    .addr_i  (slot_addr),
    .key_i   (lk_addr_i),
    .match_o (match_vec),
    .hit_o   (any_match),
    .idx_o   (hit_idx)
  );

  always_comb begin
    op = VC_NOP;
    if (req_i) begin
      if (any_match) op = ins_valid_i ? VC_SWAP : VC_TAKE;
      else if (ins_valid_i) op = VC_FILL;
    end
  end

  assign tgt_idx = (op == VC_FILL) ? lru_idx : hit_idx;

  vc_lru #(.N(ENTRIES)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (op != VC_NOP),
    .demote_i  (op == VC_TAKE),
    .idx_i     (tgt_idx),
    .lru_idx_o (lru_idx)
  );

  vc_store #(.N(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (op != VC_NOP),
    .widx_i   (tgt_idx),
    .wvalid_i (ins_valid_i),
    .wdirty_i (ins_dirty_i),
    .waddr_i  (ins_addr_i),
    .wdata_i  (ins_data_i),
    .valid_o  (slot_valid),
    .dirty_o  (slot_dirty),
    .addr_o   (slot_addr),
    .data_o   (slot_data)
  );

  assign hit_o       = req_i && any_match;
  assign hit_data_o  = slot_data[hit_idx];
  assign hit_dirty_o = slot_dirty[hit_idx];

  assign evict_valid_o = (op == VC_FILL) && slot_valid[lru_idx] && slot_dirty[lru_idx];
  assign evict_addr_o  = slot_addr[lru_idx];
  assign evict_data_o  = slot_data[lru_idx];
endmodule

// File: rtl/vc_swap_buf_chk.sv
module vc_swap_buf_chk #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [ADDR_W-1:0]  lk_addr_i,
  input logic               ins_valid_i,
  input logic [ADDR_W-1:0]  ins_addr_i,
  input logic [DATA_W-1:0]  ins_data_i,
  input logic               hit_o,
  input logic [DATA_W-1:0]  hit_data_o,
  input logic               evict_valid_o,
  input logic [ENTRIES-1:0] match_i
);
  p_single_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_i));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !hit_o && !evict_valid_o);

  p_evict_on_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> req_i && ins_valid_i && !hit_o);

  p_fill_visible_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ins_valid_i) |=>
      (!(req_i && lk_addr_i == $past(ins_addr_i)) || (hit_o && hit_data_o == $past(ins_data_i))));

  p_taken_gone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !(ins_valid_i && ins_addr_i == lk_addr_i)) |=>
      (!(req_i && lk_addr_i == $past(lk_addr_i)) || !hit_o));
endmodule

bind vc_swap_buf vc_swap_buf_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .lk_addr_i     (lk_addr_i),
  .ins_valid_i   (ins_valid_i),
  .ins_addr_i    (ins_addr_i),
  .ins_data_i    (ins_data_i),
  .hit_o         (hit_o),
  .hit_data_o    (hit_data_o),
  .evict_valid_o (evict_valid_o),
  .match_i       (match_vec)
);

// File: tb/tb_vc_swap_buf.sv
module tb_vc_swap_buf;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [ADDR_W-1:0] lk_addr_i = '0;
  logic              ins_valid_i = 1'b0;
  logic [ADDR_W-1:0] ins_addr_i = '0;
  logic [DATA_W-1:0] ins_data_i = '0;
  logic              ins_dirty_i = 1'b0;
  logic              hit_o, hit_dirty_o, evict_valid_o;
  logic [DATA_W-1:0] hit_data_o, evict_data_o;
  logic [ADDR_W-1:0] evict_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vc_swap_buf #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .lk_addr_i(lk_addr_i),
    .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i), .ins_data_i(ins_data_i),
    .ins_dirty_i(ins_dirty_i), .hit_o(hit_o), .hit_data_o(hit_data_o),
    .hit_dirty_o(hit_dirty_o), .evict_valid_o(evict_valid_o),
    .evict_addr_o(evict_addr_o), .evict_data_o(evict_data_o)
  );

  function automatic logic [DATA_W-1:0] dval(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5a5a, ~a};
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // one request; outputs sampled 1 ns after the negedge, state updates at the next posedge
  task automatic step(input string rq, input logic rq_v, input logic [ADDR_W-1:0] lk,
                      input logic iv, input logic [ADDR_W-1:0] ia, input logic idt,
                      input logic e_hit, input logic e_hdirty,
                      input logic e_ev, input logic [ADDR_W-1:0] e_eaddr);
    @(negedge clk);
    req_i = rq_v; lk_addr_i = lk; ins_valid_i = iv;
    ins_addr_i = ia; ins_data_i = dval(ia); ins_dirty_i = idt;
    #1;
    chk(rq, "hit", 64'(hit_o), 64'(e_hit));
    if (e_hit) begin
      chk(rq, "hit_data", 64'(hit_data_o), 64'(dval(lk)));
      chk(rq, "hit_dirty", 64'(hit_dirty_o), 64'(e_hdirty));
    end
    chk(rq, "evict", 64'(evict_valid_o), 64'(e_ev));
    if (e_ev) begin
      chk(rq, "evict_addr", 64'(evict_addr_o), 64'(e_eaddr));
      chk(rq, "evict_data", 64'(evict_data_o), 64'(dval(e_eaddr)));
    end
    @(posedge clk);
    #0.5;
    req_i = 1'b0; ins_valid_i = 1'b0;
  endtask

  localparam logic [ADDR_W-1:0] QX = 16'h0f00;

  task automatic t_reset();
    step("R1", 1, 16'h0000, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 16'h0010, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_fill();
    step("R3", 1, QX, 1, 16'h00a1, 0, 0, 0, 0, 0);
    step("R3", 1, QX, 1, 16'h00a2, 1, 0, 0, 0, 0);
    step("R3", 1, QX, 1, 16'h00a3, 0, 0, 0, 0, 0);
    step("R1", 1, QX, 1, 16'h00a4, 0, 0, 0, 0, 0);
    step("R6", 1, QX, 1, 16'h00a5, 1, 0, 0, 0, 0);       // clean a1 dropped
    step("R6", 1, QX, 1, 16'h00a6, 0, 0, 0, 1, 16'h00a2); // dirty a2 written back
  endtask

  task automatic t_swap();
    step("R2", 1, 16'h00a3, 1, 16'h00b1, 0, 1, 0, 0, 0);  // order b1 a6 a5 a4
    step("R7", 1, 16'h00a1, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 16'h00a4, 1, 16'h00cc, 1, 0, 0, 0, 0);
    step("R8", 1, 16'h00cc, 0, 0, 0, 0, 0, 0, 0);          // idle cycle stored nothing
    step("R4", 1, QX, 1, 16'h00c1, 0, 0, 0, 0, 0);         // displaces a4
    step("R4", 1, 16'h00a4, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 16'h00a3, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 16'h00b1, 1, 16'h00b2, 0, 1, 0, 0, 0);  // order b2 c1 a6 a5
  endtask

  task automatic t_take();
    step("R5", 1, 16'h00a5, 0, 0, 0, 1, 1, 0, 0);          // a5 leaves, slot free
    step("R5", 1, QX, 1, 16'h00e1, 1, 0, 0, 0, 0);         // into the free slot
    step("R9", 1, QX, 1, 16'h00e2, 0, 0, 0, 0, 0);         // displaces a6
    step("R9", 1, QX, 1, 16'h00e3, 0, 0, 0, 0, 0);         // displaces c1
    step("R9", 1, QX, 1, 16'h00e4, 0, 0, 0, 0, 0);         // displaces b2
    step("R5", 1, QX, 1, 16'h00e5, 0, 0, 0, 1, 16'h00e1);
    step("R9", 1, 16'h00a6, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pingpong();
    // order e5 e4 e3 e2; p and q conflict in the main cache
    step("R10", 1, 16'h0102, 1, 16'h0101, 0, 0, 0, 0, 0);  // q misses, p stored
    for (int k = 0; k < 3; k++) begin
      step("R10", 1, 16'h0101, 1, 16'h0102, 0, 1, 0, 0, 0);
      step("R10", 1, 16'h0102, 1, 16'h0101, 0, 1, 0, 0, 0);
    end
    step("R10", 1, 16'h00e3, 1, 16'h0f0f, 0, 1, 0, 0, 0);
    step("R10", 1, 16'h00e2, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_ni = 1'b1;
    t_reset();
    t_fill();
    t_swap();
    t_take();
    t_pingpong();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule